// File: doc/BRIEF.md
# Clock Output Power-Down Controller

This block is the digital shutdown and restart sequencer of a multi-output clock generator. One shared input pin has two roles, one after the other. After reset it is read as an active-low "supply good" indication. While it stays high, every output stays held and the block waits. When the pin is first seen low, the outputs start running. From then on the same pin is read as an active-high power-down request, and it never returns to the supply-good role until the next reset. The block works in a fast sampling clock domain. It sees the reference clock, the single-ended output clocks and the complement halves of the differential pairs as sampled signals, and it gates them with registered enables.

A power-down request passes through a two-flop synchronizer. It is accepted only when it is seen high at `REQ_EDGES` successive rising edges of the reference clock. After acceptance, each single-ended output is gated low at its next falling edge. Each differential pair is parked at the next falling edge of its complement. Each of the three pair groups (processor, peripheral, display) has a park-mode bit that picks the parked form. The oscillator-off and VCO-off flags rise only after every output is held.

When the request drops, both off flags clear at once. The outputs then stay held for `SETTLE_REFS` reference rising edges. After that, each output restarts just after its own next falling edge, so no output ever produces a truncated pulse.

Top module: `clkout_pd_ctrl`

## Requirements
- R1: After reset, `pd_pin` is read as active-low supply-good. While it stays high, `se_clk_o` is all zero, `dif_c_oe` is all zero, and `osc_off`/`vco_off` stay 0. A high pin in this phase never starts a shutdown.
- R2: Once the synchronized pin is seen low in the supply-good phase, every output starts toggling. Each output starts just after a falling edge of its input, and `dif_c_oe` becomes all ones.
- R3: A request that is high at only one reference rising edge is ignored. The outputs keep toggling and `osc_off` stays 0.
- R4: A request held high is accepted at the second successive reference rising edge that sees it high (REQ_EDGES = 2). `osc_off` cannot rise sooner than 10 fast-clock cycles after the pin rises.
- R5: Every high pulse on `se_clk_o[i]` is exactly as long as the high phase of `se_clk_i[i]`. After acceptance, each single-ended output is held low from its next falling edge.
- R6: A pair stops at a falling edge of its complement. When `dif_c_oe[g]` drops, `dif_c_i[g]` is low.
- R7: Park-mode bit `park_mode[g]` = 0 (bit 0 processor, bit 1 peripheral, bit 2 display) parks group g with `dif_t_oe`=1, `dif_t_o`=1 and `dif_c_oe`=0.
- R8: Park-mode bit `park_mode[g]` = 1 parks group g with both `dif_t_oe` and `dif_c_oe` at 0.
- R9: `osc_off` and `vco_off` are 1 only while all single-ended outputs are low and every pair is parked.
- R10: When the request drops, `osc_off`/`vco_off` clear first. Outputs stay held for SETTLE_REFS (4) reference rising edges, so at least 24 fast cycles pass before any single-ended output goes high again, and then all outputs resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pin | input | 1 | Shared pin: supply-good (active low), then power-down request (active high) |
| ref_clk | input | 1 | Reference clock, true half |
| se_clk_i | input | N_SE | Single-ended clocks to be gated |
| dif_t_i | input | 3 | True halves of the differential pairs |
| dif_c_i | input | 3 | Complement halves of the differential pairs |
| park_mode | input | 3 | Per-group parked form select |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| dif_t_o | output | 3 | True-half output value |
| dif_t_oe | output | 3 | True-half drive enable |
| dif_c_o | output | 3 | Complement-half output value |
| dif_c_oe | output | 3 | Complement-half drive enable |
| osc_off | output | 1 | Crystal oscillator may stop |
| vco_off | output | 1 | VCOs may stop |

## Verification
Request acceptance and output stopping can fall in the same cycle. The group-0 pair runs in phase with the reference clock, so its complement falls exactly when the accepting reference edge arrives. The bench holds the request high across such an edge. A per-cycle monitor then checks that the pair is parked only at a later complement fall, and never while the complement is high. The same monitor confirms that no single-ended pulse is cut short, and that both off flags stay low until every output is held.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    localparam int GRP_COUNT = 3;

    typedef enum logic [2:0] {
        PH_PWRGD,
        PH_RUN,
        PH_STOP,
        PH_HELD,
        PH_WAKE,
        PH_RESUME
    } phase_e;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdc_edges.sv
module pdc_edges #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/pdc_park.sv
module pdc_park (
    input  logic en_i,
    input  logic mode_i,
    input  logic t_i,
    input  logic c_i,
    output logic t_o,
    output logic t_oe,
    output logic c_o,
    output logic c_oe
);
    always_comb begin
        t_o  = en_i ? t_i : 1'b1;
        t_oe = en_i | ~mode_i;
        c_o  = en_i ? c_i : 1'b0;
        c_oe = en_i;
    end
endmodule

// File: rtl/clkout_pd_ctrl.sv
module clkout_pd_ctrl #(
    parameter int N_SE        = 2,
    parameter int REQ_EDGES   = 2,
    parameter int SETTLE_REFS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pd_pin,
    input  logic                           ref_clk,
    input  logic [N_SE-1:0]                se_clk_i,
    input  logic [pdc_pkg::GRP_COUNT-1:0]  dif_t_i,
    input  logic [pdc_pkg::GRP_COUNT-1:0]  dif_c_i,
    input  logic [pdc_pkg::GRP_COUNT-1:0]  park_mode,
    output logic [N_SE-1:0]                se_clk_o,
    output logic [pdc_pkg::GRP_COUNT-1:0]  dif_t_o,
    output logic [pdc_pkg::GRP_COUNT-1:0]  dif_t_oe,
    output logic [pdc_pkg::GRP_COUNT-1:0]  dif_c_o,
    output logic [pdc_pkg::GRP_COUNT-1:0]  dif_c_oe,
    output logic                           osc_off,
    output logic                           vco_off
);
    import pdc_pkg::*;

    localparam int GRP   = GRP_COUNT;
    localparam int REQ_W = $clog2(REQ_EDGES + 1);
    localparam int SET_W = $clog2(SETTLE_REFS + 1);
    localparam int EDG_W = 1 + GRP + N_SE;

    typedef struct packed {
        phase_e           ph;
        logic [N_SE-1:0]  se_en;
        logic [GRP-1:0]   dif_en;
        logic [REQ_W-1:0] req_cnt;
        logic [SET_W-1:0] settle;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             pin_s;
    logic [EDG_W-1:0] falls;
    logic             ref_rise;
    logic [GRP-1:0]   c_fall;
    logic [N_SE-1:0]  se_fall;

    pdc_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pd_pin),
        .sync_o  (pin_s)
    );

    // The inverted reference makes a rising edge look like a falling one.
    pdc_edges #(.W(EDG_W)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({~ref_clk, dif_c_i, se_clk_i}),
        .fall_o (falls)
    );

    assign ref_rise = falls[EDG_W-1];
    assign c_fall   = falls[N_SE +: GRP];
    assign se_fall  = falls[N_SE-1:0];

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.ph)
            PH_PWRGD: begin
                if (!pin_s) ctl_d.ph = PH_RESUME;
            end
            PH_RUN: begin
                if (ref_rise) begin
                    if (pin_s) begin
                        if (ctl_q.req_cnt == REQ_W'(REQ_EDGES - 1)) begin
                            ctl_d.ph      = PH_STOP;
                            ctl_d.req_cnt = '0;
                        end else begin
                            ctl_d.req_cnt = ctl_q.req_cnt + 1'b1;
                        end
                    end else begin
                        ctl_d.req_cnt = '0;
                    end
                end
            end
            PH_STOP: begin
                ctl_d.se_en  = ctl_q.se_en  & ~se_fall;
                ctl_d.dif_en = ctl_q.dif_en & ~c_fall;
                if (ctl_q.se_en == '0 && ctl_q.dif_en == '0) ctl_d.ph = PH_HELD;
            end
            PH_HELD: begin
                if (!pin_s) begin
                    ctl_d.ph     = PH_WAKE;
                    ctl_d.settle = '0;
                end
            end
            PH_WAKE: begin
                if (ref_rise) begin
                    if (ctl_q.settle == SET_W'(SETTLE_REFS - 1)) begin
                        ctl_d.ph     = PH_RESUME;
                        ctl_d.settle = '0;
                    end else begin
                        ctl_d.settle = ctl_q.settle + 1'b1;
                    end
                end
            end
            PH_RESUME: begin
                ctl_d.se_en  = ctl_q.se_en  | se_fall;
                ctl_d.dif_en = ctl_q.dif_en | c_fall;
                if ((&ctl_q.se_en) && (&ctl_q.dif_en)) begin
                    ctl_d.ph      = PH_RUN;
                    ctl_d.req_cnt = '0;
                end
            end
            default: ctl_d.ph = PH_PWRGD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{ph: PH_PWRGD, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign se_clk_o = se_clk_i & ctl_q.se_en;
    assign osc_off  = (ctl_q.ph == PH_HELD);
    assign vco_off  = (ctl_q.ph == PH_HELD);

    for (genvar g = 0; g < GRP; g++) begin : g_pair
        pdc_park u_park (
            .en_i   (ctl_q.dif_en[g]),
            .mode_i (park_mode[g]),
            .t_i    (dif_t_i[g]),
            .c_i    (dif_c_i[g]),
            .t_o    (dif_t_o[g]),
            .t_oe   (dif_t_oe[g]),
            .c_o    (dif_c_o[g]),
            .c_oe   (dif_c_oe[g])
        );
    end
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
    parameter int N_SE = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [N_SE-1:0]               se_clk_i,
    input logic [pdc_pkg::GRP_COUNT-1:0] dif_c_i,
    input logic [pdc_pkg::GRP_COUNT-1:0] park_mode,
    input logic [N_SE-1:0]               se_clk_o,
    input logic [pdc_pkg::GRP_COUNT-1:0] dif_t_o,
    input logic [pdc_pkg::GRP_COUNT-1:0] dif_t_oe,
    input logic [pdc_pkg::GRP_COUNT-1:0] dif_c_oe,
    input logic                          osc_off,
    input logic                          vco_off
);
    for (genvar i = 0; i < N_SE; i++) begin : g_se
        assert_no_runt_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(se_clk_o[i]) |-> $rose(se_clk_i[i]));
        assert_no_runt_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(se_clk_o[i]) |-> $fell(se_clk_i[i]));
    end

    for (genvar g = 0; g < pdc_pkg::GRP_COUNT; g++) begin : g_dif
        assert_park_at_c_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dif_c_oe[g]) |-> !dif_c_i[g]);
        assert_park_drive_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!dif_c_oe[g] && !park_mode[g]) |-> (dif_t_oe[g] && dif_t_o[g]));
        assert_park_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!dif_c_oe[g] && park_mode[g]) |-> !dif_t_oe[g]);
    end

    assert_osc_after_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off |-> (se_clk_o == '0 && dif_c_oe == '0));
    assert_vco_after_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vco_off |-> (se_clk_o == '0 && dif_c_oe == '0));
    assert_settle_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_off) |=> (se_clk_o == '0 && dif_c_oe == '0));
endmodule

bind clkout_pd_ctrl pdc_checker #(.N_SE(N_SE)) u_pdc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .se_clk_i  (se_clk_i),
    .dif_c_i   (dif_c_i),
    .park_mode (park_mode),
    .se_clk_o  (se_clk_o),
    .dif_t_o   (dif_t_o),
    .dif_t_oe  (dif_t_oe),
    .dif_c_oe  (dif_c_oe),
    .osc_off   (osc_off),
    .vco_off   (vco_off)
);

// File: tb/clkout_pd_ctrl_test.sv
module clkout_pd_ctrl_test;
    localparam int N_SE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_pin = 1'b1;
    logic       ref_clk = 1'b0;
    logic [1:0] se_clk_i = '0;
    logic [2:0] dif_t_i = '0;
    logic [2:0] dif_c_i = '1;
    logic [2:0] park_mode = '0;
    logic [1:0] se_clk_o;
    logic [2:0] dif_t_o, dif_t_oe, dif_c_o, dif_c_oe;
    logic       osc_off, vco_off;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    clkout_pd_ctrl #(.N_SE(N_SE)) uut (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .ref_clk(ref_clk),
        .se_clk_i(se_clk_i), .dif_t_i(dif_t_i), .dif_c_i(dif_c_i),
        .park_mode(park_mode), .se_clk_o(se_clk_o), .dif_t_o(dif_t_o),
        .dif_t_oe(dif_t_oe), .dif_c_o(dif_c_o), .dif_c_oe(dif_c_oe),
        .osc_off(osc_off), .vco_off(vco_off)
    );

    // Clock sources: ref period 8, singles 6 and 10, pairs 8, 12, 10.
    int gen_cyc = 0;
    initial forever begin
        @(negedge clk);
        gen_cyc++;
        ref_clk     = (gen_cyc % 8)  < 4;
        se_clk_i[0] = (gen_cyc % 6)  < 3;
        se_clk_i[1] = (gen_cyc % 10) < 5;
        dif_t_i[0]  = (gen_cyc % 8)  < 4;
        dif_t_i[1]  = (gen_cyc % 12) < 6;
        dif_t_i[2]  = (gen_cyc % 10) < 5;
        dif_c_i     = ~dif_t_i;
    end

    // Continuous monitor, sampled mid-cycle.
    int         mcyc = 0;
    int         run_len [2] = '{0, 0};
    int         bad_pulse = 0, bad_hold = 0, bad_park = 0;
    logic [1:0] se_seen = '0;
    logic       osc_seen = 1'b0;
    logic       prev_osc = 1'b0;
    logic [2:0] prev_coe = '0;
    int         wake_cyc = -1;
    int         wake_gap = -1;
    initial forever begin
        @(posedge clk); #5;
        mcyc++;
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (se_clk_o[i]) begin
                    run_len[i]++;
                    se_seen[i] = 1'b1;
                end else if (run_len[i] > 0) begin
                    if (run_len[i] != ((i == 0) ? 3 : 5)) bad_pulse++;
                    run_len[i] = 0;
                end
            end
            if (osc_off || vco_off) begin
                osc_seen = 1'b1;
                if (se_clk_o != 0 || dif_c_oe != 0 || dif_t_oe != ~park_mode) bad_hold++;
            end
            for (int g = 0; g < 3; g++)
                if (prev_coe[g] && !dif_c_oe[g] && dif_c_i[g]) bad_park++;
            if (prev_osc && !osc_off) begin
                wake_cyc = mcyc;
                wake_gap = -1;
            end
            if (wake_cyc >= 0 && wake_gap < 0 && se_clk_o != 0) wake_gap = mcyc - wake_cyc;
            prev_osc = osc_off;
            prev_coe = dif_c_oe;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sample();
        @(posedge clk); #5;
    endtask

    task automatic t_reset();
        repeat (3) sample();
        check(se_clk_o == 0, "R1 outputs held after reset", se_clk_o, 0);
        check(osc_off == 0 && vco_off == 0, "R1 off flags low after reset", osc_off, 0);
        se_seen  = '0;
        osc_seen = 1'b0;
        repeat (40) sample();
        check(se_seen == 0, "R1 no output while supply not good", se_seen, 0);
        check(osc_seen == 0, "R1 high pin not a request yet", osc_seen, 0);
        check(dif_c_oe == 0, "R1 pairs parked before supply good", dif_c_oe, 0);
    endtask

    task automatic t_supply_good();
        @(negedge clk) pd_pin = 1'b0;
        se_seen = '0;
        repeat (60) sample();
        check(se_seen == 2'b11, "R2 singles started", se_seen, 3);
        check(dif_c_oe == 3'b111, "R2 pairs started", dif_c_oe, 7);
        check(bad_pulse == 0, "R2 clean start pulses", bad_pulse, 0);
    endtask

    task automatic t_one_edge();
        @(posedge ref_clk);
        repeat (2) @(negedge clk);
        pd_pin = 1'b1;
        repeat (6) @(negedge clk);
        pd_pin   = 1'b0;
        osc_seen = 1'b0;
        se_seen  = '0;
        repeat (60) sample();
        check(osc_seen == 0, "R3 single-edge request ignored", osc_seen, 0);
        check(se_seen == 2'b11, "R3 outputs keep running", se_seen, 3);
    endtask

    task automatic t_power_down(input logic [2:0] mode);
        int waited = 0;
        @(negedge clk);
        park_mode = mode;
        pd_pin    = 1'b1;
        while (!osc_off && waited < 200) begin
            sample();
            waited++;
        end
        check(osc_off == 1, "R4 held request accepted", osc_off, 1);
        check(waited >= 10, "R4 not accepted before two edges", waited, 10);
        check(se_clk_o == 0, "R5 singles held low", se_clk_o, 0);
        for (int g = 0; g < 3; g++) begin
            if (!mode[g])
                check(dif_t_oe[g] && dif_t_o[g] && !dif_c_oe[g], "R7 park true high, complement floating",
                      {dif_t_oe[g], dif_t_o[g], dif_c_oe[g]}, 3'b110);
            else
                check(!dif_t_oe[g] && !dif_c_oe[g], "R8 park both floating",
                      {dif_t_oe[g], dif_c_oe[g]}, 0);
        end
        repeat (20) sample();
        check(osc_off && vco_off, "R9 off flags stay while request held", {osc_off, vco_off}, 3);
    endtask

    task automatic t_release();
        int waited = 0;
        @(negedge clk) pd_pin = 1'b0;
        sample();
        repeat (3) sample();
        check(osc_off == 0 && vco_off == 0, "R10 off flags clear first", {osc_off, vco_off}, 0);
        check(se_clk_o == 0 && dif_c_oe == 0, "R10 outputs still held while settling", se_clk_o, 0);
        while (wake_gap < 0 && waited < 200) begin
            sample();
            waited++;
        end
        check(wake_gap >= 24, "R10 settle interval before restart", wake_gap, 24);
        repeat (30) sample();
        check(dif_c_oe == 3'b111, "R10 pairs resumed", dif_c_oe, 7);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_supply_good();
        t_one_edge();
        t_power_down(3'b010);
        t_release();
        t_power_down(3'b101);
        t_release();
        check(bad_pulse == 0, "R5 no truncated single-ended pulse", bad_pulse, 0);
        check(bad_park == 0, "R6 pairs parked only with complement low", bad_park, 0);
        check(bad_hold == 0, "R9 off flags only with all outputs held", bad_hold, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule